// File: doc/BRIEF.md
# Four-Channel PWM Timer

This block is a memory-mapped pulse-width modulation timer. A free-running prescaler divides the system clock to produce count ticks. On each tick an up-counter advances from zero to a programmable reload value and then returns to zero. Four compare channels each turn the counter into a pulse train. A channel's reference is active while the count is below that channel's compare value. Each channel drives a main output and a complementary output. Every output has its own enable and inversion bit, and one master gate in the control word silences all eight lines.

Software uses a simple word-addressed register bus: a write strobe, an address, write data and combinational read data. Compare and reload writes go to shadow copies. These copies reach the counter only on an update event, which is either the counter wrapping or a software-forced update. A new duty cycle therefore never cuts a period short. The status word records wrap and compare-match events. Writing a 0 to a status bit clears it, and writing a 1 leaves it unchanged. The interrupt line is raised while any status bit is set and its enable bit is also set.

Top module: `pwm4_timer`

## Requirements
- R1: The prescaler value is held in word 4 and is 16 bits wide. The counter advances once every (prescaler + 1) clock cycles while counting is enabled.
- R2: The counter counts 0, 1, ..., reload and then returns to 0, so one period is (reload + 1) ticks. The reload value is in word 5, and word 6 reads the live count.
- R3: The reference of channel n is active while the count is strictly below the active compare value of that channel. The compare value is in word 8+n. A value of 0 is never active, and a value above the reload value is always active.
- R4: Word 7 holds one nibble per channel, with nibble n at bits 4n+3..4n. Bit 0 of the nibble enables the main output and bit 1 inverts it. A disabled main output sits at 0.
- R5: Nibble bit 2 enables the complementary output and nibble bit 3 inverts it. Before inversion, the complementary output is the inverse of the reference. A disabled complementary output sits at 0.
- R6: Bit 2 of the control word (word 0) is the master output gate. While it is 0, all main and complementary outputs are 0, and this includes the state after reset.
- R7: Writes to the compare and reload words land in shadow registers, and these shadow registers read back at the same address. The counter and the outputs use the shadow values only after the next update event.
- R8: Writing 1 to bit 0 of word 1 forces an update event. This copies the shadows into the active registers and sets the counter and prescaler to 0. Word 1 reads as 0.
- R9: Bit 1 of the control word selects the update-flag source. When this bit is set, only a counter wrap sets status bit 0, and a forced update does not.
- R10: Status bit 0 (word 3) is set by an update event. Status bit n+1 is set when a tick moves the counter onto the active compare value of channel n. A compare value above the reload value never sets its flag.
- R11: A write to the status word clears each bit written as 0 and keeps each bit written as 1. An event in the same cycle as the write sets its bit anyway.
- R12: The interrupt output is 1 exactly when some status bit and the matching bit of the interrupt-enable word (word 2, same bit layout) are both 1.
- R13: Control bit 0 enables counting. While it is 0, the counter and prescaler keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 1 | Interrupt request |
| pwm_out | output | 4 | Main output per channel |
| pwm_out_n | output | 4 | Complementary output per channel |

## Verification
A wrong prescaler or reload comparison changes how many clock cycles each output is high over a whole number of periods. This error therefore shows up as a wrong high-time count within the first few periods of a sweep. A shadow register that leaks through early shows up at once on a stopped counter, because the output flips before any update is issued. Errors in the status flags reach the ports through the status read-back and the interrupt line. A wrong clear mask or a wrong flag source is visible on the very next read.

// File: rtl/pwm4_pkg.sv
package pwm4_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] ADR_CTRL   = 4'h0;
  localparam logic [ADDR_W-1:0] ADR_EVENT  = 4'h1;
  localparam logic [ADDR_W-1:0] ADR_IEN    = 4'h2;
  localparam logic [ADDR_W-1:0] ADR_STAT   = 4'h3;
  localparam logic [ADDR_W-1:0] ADR_PSC    = 4'h4;
  localparam logic [ADDR_W-1:0] ADR_RELOAD = 4'h5;
  localparam logic [ADDR_W-1:0] ADR_COUNT  = 4'h6;
  localparam logic [ADDR_W-1:0] ADR_OUTCFG = 4'h7;
  localparam logic [ADDR_W-1:0] ADR_CMP0   = 4'h8;

  // per-channel output configuration nibble (bit 0 = en)
  typedef struct packed {
    logic cinv;
    logic cena;
    logic inv;
    logic ena;
  } chcfg_t;

  // gated, optionally inverted output level
  function automatic logic drive_level(logic act, logic ena, logic inv, logic gate);
    return gate & ena & (act ^ inv);
  endfunction

  // counter successor: forced restart, wrap at reload, or step
  function automatic logic [31:0] next_count(logic [31:0] cur, logic [31:0] lim,
                                             logic force0, logic step);
    if (force0) return '0;
    if (!step) return cur;
    if (cur == lim) return '0;
    return cur + 32'd1;
  endfunction
endpackage

// File: rtl/pwm4_counter.sv
module pwm4_counter #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             force_upd,
  input  logic [PSC_W-1:0] psc,
  input  logic [CNT_W-1:0] reload_sh,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             step,
  output logic             wrap,
  output logic             upd
);
  import pwm4_pkg::*;

  logic [PSC_W-1:0] psc_q;
  logic [CNT_W-1:0] reload_act;
  logic             tick;
  logic [31:0]      nxt32;

  assign tick = run & (psc_q >= psc);
  assign wrap = tick & ~force_upd & (cnt == reload_act);
  assign upd  = force_upd | wrap;
  assign step = tick & ~force_upd;
  assign nxt32   = next_count(32'(cnt), 32'(reload_act), force_upd, tick);
  assign cnt_nxt = nxt32[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      psc_q      <= '0;
      cnt        <= '0;
      reload_act <= '0;
    end else begin
      if (force_upd)  psc_q <= '0;
      else if (run)   psc_q <= tick ? '0 : psc_q + 1'b1;
      cnt <= cnt_nxt;
      if (upd) reload_act <= reload_sh;
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= reload_act);                                               // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !force_upd) |=> $stable(cnt));                           // R13
  AST_FORCE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    force_upd |=> (cnt == '0));                                       // R8
endmodule

// File: rtl/pwm4_channel.sv
module pwm4_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic             step,
  input  logic             upd,
  input  logic [CNT_W-1:0] cmp_sh,
  input  pwm4_pkg::chcfg_t cfg,
  input  logic             gate,
  output logic             out_p,
  output logic             out_n,
  output logic             match
);
  import pwm4_pkg::*;

  logic [CNT_W-1:0] cmp_act;
  logic [CNT_W-1:0] cmp_eff;
  logic             ref_on;

  assign cmp_eff = upd ? cmp_sh : cmp_act;
  assign match   = step & (cnt_nxt == cmp_eff);
  assign ref_on  = (cnt < cmp_act);
  assign out_p   = drive_level(ref_on, cfg.ena, cfg.inv, gate);
  assign out_n   = drive_level(~ref_on, cfg.cena, cfg.cinv, gate);

  always_ff @(posedge clk) begin
    if (!rst_n)   cmp_act <= '0;
    else if (upd) cmp_act <= cmp_sh;
  end

  AST_CMP_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmp_act) |-> (cnt == '0));                               // R7
endmodule

// File: rtl/pwm4_regs.sv
module pwm4_regs #(
  parameter int NCH   = 4,
  parameter int CNT_W = 16,
  parameter int PSC_W = 16,
  localparam int SW   = NCH + 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr,
  input  logic [pwm4_pkg::ADDR_W-1:0]    addr,
  input  logic [pwm4_pkg::DATA_W-1:0]    wdata,
  output logic [pwm4_pkg::DATA_W-1:0]    rdata,
  input  logic                           wrap,
  input  logic [NCH-1:0]                 match,
  input  logic [CNT_W-1:0]               cnt,
  output logic                           run,
  output logic                           urs,
  output logic                           gate,
  output logic                           force_upd,
  output logic [PSC_W-1:0]               psc,
  output logic [CNT_W-1:0]               reload_sh,
  output logic [NCH-1:0][CNT_W-1:0]      cmp_sh,
  output pwm4_pkg::chcfg_t [NCH-1:0]     cfg,
  output logic                           irq
);
  import pwm4_pkg::*;

  logic [SW-1:0] ien;
  logic [SW-1:0] stat;
  logic [SW-1:0] stat_nxt;
  logic [SW-1:0] events;
  logic          stat_wr;
  logic          unused_wbits;

  assign unused_wbits = ^wdata;
  assign force_upd = wr && (addr == ADR_EVENT) && wdata[0];
  assign stat_wr   = wr && (addr == ADR_STAT);
  assign events    = {match, wrap | (force_upd & ~urs)};

  always_comb begin
    stat_nxt = stat;
    if (stat_wr) stat_nxt = stat_nxt & wdata[SW-1:0];
    stat_nxt = stat_nxt | events;
  end

  assign irq = |(stat & ien);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0; urs <= 1'b0; gate <= 1'b0;
      ien <= '0; stat <= '0; psc <= '0; reload_sh <= '0;
      cmp_sh <= '0; cfg <= '0;
    end else begin
      stat <= stat_nxt;
      if (wr) begin
        case (addr)
          ADR_CTRL:   {gate, urs, run} <= wdata[2:0];
          ADR_IEN:    ien <= wdata[SW-1:0];
          ADR_PSC:    psc <= wdata[PSC_W-1:0];
          ADR_RELOAD: reload_sh <= wdata[CNT_W-1:0];
          ADR_OUTCFG: cfg <= wdata[4*NCH-1:0];
          default: ;
        endcase
        for (int i = 0; i < NCH; i++)
          if (addr == ADR_CMP0 + ADDR_W'(i)) cmp_sh[i] <= wdata[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADR_CTRL:   rdata = DATA_W'({gate, urs, run});
      ADR_IEN:    rdata = DATA_W'(ien);
      ADR_STAT:   rdata = DATA_W'(stat);
      ADR_PSC:    rdata = DATA_W'(psc);
      ADR_RELOAD: rdata = DATA_W'(reload_sh);
      ADR_COUNT:  rdata = DATA_W'(cnt);
      ADR_OUTCFG: rdata = DATA_W'(cfg);
      default: ;
    endcase
    for (int i = 0; i < NCH; i++)
      if (addr == ADR_CMP0 + ADDR_W'(i)) rdata = DATA_W'(cmp_sh[i]);
  end

  AST_URS_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (urs && force_upd && !wrap && !stat[0]) |=> !stat[0]);           // R9
  AST_W0C: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && wdata[0] == 1'b0 && !wrap && !(force_upd && !urs)) |=> !stat[0]); // R11
  AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0) |-> !irq);                                            // R12
  AST_MATCH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (match[0]) |=> stat[1]);                                          // R10
endmodule

// File: rtl/pwm4_timer.sv
module pwm4_timer #(
  parameter int NCH   = 4,
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bus_wr,
  input  logic [pwm4_pkg::ADDR_W-1:0]  bus_addr,
  input  logic [pwm4_pkg::DATA_W-1:0]  bus_wdata,
  output logic [pwm4_pkg::DATA_W-1:0]  bus_rdata,
  output logic                         irq,
  output logic [NCH-1:0]               pwm_out,
  output logic [NCH-1:0]               pwm_out_n
);
  import pwm4_pkg::*;

  logic                     run, urs, gate, force_upd;
  logic [PSC_W-1:0]         psc;
  logic [CNT_W-1:0]         reload_sh, cnt, cnt_nxt;
  logic [NCH-1:0][CNT_W-1:0] cmp_sh;
  chcfg_t [NCH-1:0]         cfg;
  logic                     step, wrap, upd;
  logic [NCH-1:0]           match;

  pwm4_regs #(.NCH(NCH), .CNT_W(CNT_W), .PSC_W(PSC_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .rdata(bus_rdata), .wrap(wrap), .match(match), .cnt(cnt), .run(run),
    .urs(urs), .gate(gate), .force_upd(force_upd), .psc(psc),
    .reload_sh(reload_sh), .cmp_sh(cmp_sh), .cfg(cfg), .irq(irq)
  );

  pwm4_counter #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .force_upd(force_upd), .psc(psc),
    .reload_sh(reload_sh), .cnt(cnt), .cnt_nxt(cnt_nxt), .step(step),
    .wrap(wrap), .upd(upd)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pwm4_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .cnt(cnt), .cnt_nxt(cnt_nxt), .step(step),
      .upd(upd), .cmp_sh(cmp_sh[g]), .cfg(cfg[g]), .gate(gate),
      .out_p(pwm_out[g]), .out_n(pwm_out_n[g]), .match(match[g])
    );
  end

  AST_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !gate |-> (pwm_out == '0 && pwm_out_n == '0));                    // R6
endmodule

// File: tb/pwm4_timer_tb.sv
module pwm4_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  logic [3:0]  pwm_out, pwm_out_n;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  pwm4_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .pwm_out(pwm_out), .pwm_out_n(pwm_out_n)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = 32'(d);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(int a, output int d);
    @(negedge clk);
    bus_addr = 4'(a);
    #1 d = int'(bus_rdata);
  endtask

  // stop, program, force an update, then start with the gate on
  task automatic setup(int p, int r, int c0, int c1, int c2, int c3, int cfgw);
    wr(0, 4); wr(4, p); wr(5, r);
    wr(8, c0); wr(9, c1); wr(10, c2); wr(11, c3);
    wr(7, cfgw); wr(1, 1); wr(0, 5);
  endtask

  int rlist[3] = '{2, 3, 5};

  initial begin : main
    int v, v2, mx, w, h, k;
    int hp[4], hn[4], cm[4], cv[4];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check("R6 reset main", int'(pwm_out), 0);
    check("R6 reset compl", int'(pwm_out_n), 0);
    check("R12 reset irq", int'(irq), 0);
    rd(3, v); check("R10 reset status", v, 0);
    rd(1, v); check("R8 event reads 0", v, 0);

    // sweep prescaler, reload, compare and output configuration
    k = 0;
    for (int p = 0; p < 3; p++) begin
      for (int ri = 0; ri < 3; ri++) begin
        int r;
        r = rlist[ri];
        cv = '{0, 1, r, r + 1};
        w = 0;
        for (int i = 0; i < 4; i++) begin
          int en, inv, cen, cinv;
          cm[i] = cv[(i + k) % 4];
          en = (i == k % 4) ? 0 : 1;
          inv = (k + i) % 2;
          cen = (i == (k + 1) % 4) ? 0 : 1;
          cinv = ((k >> 1) + i) % 2;
          w = w | ((en | (inv << 1) | (cen << 2) | (cinv << 3)) << (4 * i));
        end
        setup(p, r, cm[0], cm[1], cm[2], cm[3], w);
        hp = '{0, 0, 0, 0}; hn = '{0, 0, 0, 0};
        for (int t = 0; t < 3 * (p + 1) * (r + 1); t++) begin
          @(negedge clk);
          for (int i = 0; i < 4; i++) begin
            hp[i] += int'(pwm_out[i]);
            hn[i] += int'(pwm_out_n[i]);
          end
        end
        for (int i = 0; i < 4; i++) begin
          int tot, ex, nib;
          tot = 3 * (p + 1) * (r + 1);
          h = 3 * (p + 1) * ((cm[i] < r + 1) ? cm[i] : r + 1);   // R1 R3
          nib = (w >> (4 * i)) & 15;
          ex = (nib & 1) ? ((nib & 2) ? tot - h : h) : 0;
          check($sformatf("R1/R3/R4 main ch%0d p%0d r%0d", i, p, r), hp[i], ex);
          ex = (nib & 4) ? ((nib & 8) ? h : tot - h) : 0;
          check($sformatf("R5 compl ch%0d p%0d r%0d", i, p, r), hn[i], ex);
        end
        k++;
      end
    end

    // R6: gate off while running silences all outputs
    wr(0, 1);
    h = 0;
    repeat (20) begin
      @(negedge clk);
      h += int'(pwm_out) + int'(pwm_out_n);
    end
    check("R6 gate off", h, 0);

    // R2: count range over one full period
    setup(1, 3, 1, 1, 1, 1, 16'h1111);
    mx = 0; h = 0;
    for (int t = 0; t < 8; t++) begin
      rd(6, v);
      if (v > mx) mx = v;
      if (v > 3) h++;
    end
    check("R2 count max", mx, 3);
    check("R2 count in range", h, 0);

    // R13: stop and hold
    wr(0, 4);
    rd(6, v);
    repeat (15) @(negedge clk);
    rd(6, v2);
    check("R13 count hold", v2, v);

    // R7/R8: shadow compare on a stopped counter
    setup(0, 9, 5, 0, 0, 0, 16'h0001);
    wr(0, 4);
    wr(1, 1);
    rd(6, v); check("R8 count cleared", v, 0);
    @(negedge clk); check("R3 active at 0<5", int'(pwm_out[0]), 1);
    wr(8, 0);
    rd(8, v); check("R7 shadow readback", v, 0);
    @(negedge clk); check("R7 output unchanged before update", int'(pwm_out[0]), 1);
    wr(1, 1);
    @(negedge clk); check("R8 update loads compare", int'(pwm_out[0]), 0);

    // R9: update-flag source
    wr(3, 0);
    wr(0, 6); wr(1, 1);
    rd(3, v); check("R9 forced update ignored", v & 1, 0);
    wr(0, 4); wr(1, 1);
    rd(3, v); check("R9 forced update flags", v & 1, 1);

    // R10/R11: compare flags then write-zero clear
    setup(0, 3, 1, 2, 3, 7, 16'h0000);
    wr(3, 0);
    repeat (10) @(negedge clk);
    wr(0, 4);
    rd(3, v); check("R10 status flags", v, 32'h0F);
    wr(3, 32'h15);
    rd(3, v); check("R11 write-zero clear", v, 32'h05);

    // R12: interrupt masking
    wr(2, 0);  @(negedge clk); check("R12 irq masked", int'(irq), 0);
    wr(2, 2);  @(negedge clk); check("R12 irq other bit", int'(irq), 0);
    wr(2, 4);  @(negedge clk); check("R12 irq raised", int'(irq), 1);
    wr(3, 0);  @(negedge clk); check("R12 irq after clear", int'(irq), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule